// File: doc/BRIEF.md
# SPI Memory-Mapped Target

This block is the serial front door of a larger device. An external host reaches the device's internal byte-addressed memory and register space through an SPI link running in mode 0 with 8-bit frames. Each transaction lasts as long as the active-low chip select stays low. The host opens a transaction with a three-byte header. Two bits at the top of the first byte select the operation, and the remaining 22 bits form a start address. A write streams data bytes straight into memory. A read skips one dummy byte and then streams memory bytes back on MISO. A short command frame raises a one-cycle command strobe once chip select is released.

All SPI pins are sampled in the block's own clock domain. Internally the block drives a simple synchronous memory port. A read strobe fetches a byte that must be valid one clock later, and a write strobe stores a byte. The address advances by one after every data byte. The host therefore transfers multi-byte quantities least-significant byte first, and they land in little-endian order. One fixed address is served inside the block as a read-only identification byte.

The system clock must be fast enough that every SCK high and low phase spans at least five clock cycles.

Top module: `spi_mmap_target`

## Requirements
- R1: MOSI is sampled on rising SCK edges, most significant bit first. MISO changes only in response to falling SCK edges. Bits are counted into bytes only while chip select is low.
- R2: The first three bytes form the header. Bits 7:6 of byte 0 are the operation: 10 is a write, 00 is a read, 01 is a command and 11 is reserved. Bits 5:0 of byte 0 are address bits 21:16, byte 1 is bits 15:8 and byte 2 is bits 7:0.
- R3: In a write, every complete byte after the header produces exactly one clock cycle of `mem_we`, with the current address and that byte on the port.
- R4: In a read, the fourth byte is a dummy whose value is ignored. MISO is 0 throughout the header and the dummy byte, and whenever chip select is high. From the fifth byte on, MISO carries memory bytes MSB first, and each byte's MSB is present before that byte's first rising SCK edge.
- R5: The address increases by one after each data byte in both reads and writes, and wraps from 0x3FFFFF to 0. A value sent least-significant byte first is therefore stored little-endian.
- R6: A read of address `ID_ADDR` (default 0x0C0000) returns 0x7C whatever the memory holds. A write to that address raises no `mem_we`, but it still advances the address.
- R7: A frame ends with exactly three complete bytes, the last two of them zero, and its first byte either has prefix 01 or equals 0x00. Such a frame gives one single-cycle `cmd_valid` pulse after chip select rises, with `cmd_code` equal to that first byte. Any other frame gives no pulse.
- R8: A frame with prefix 11 causes no memory access and no command strobe, and MISO stays 0 for the whole frame.
- R9: When chip select rises in the middle of a byte, the partial byte is discarded and causes no write. The next frame starts decoding again from header byte 0.
- R10: After reset, `mem_we`, `mem_re`, `cmd_valid` and `spi_miso` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sck | input | 1 | SPI serial clock, idle low |
| spi_cs_n | input | 1 | Active-low chip select framing a transaction |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| mem_addr | output | ADDR_W | Memory port byte address |
| mem_wdata | output | 8 | Memory port write byte |
| mem_we | output | 1 | Memory write strobe, one cycle per byte |
| mem_re | output | 1 | Memory read strobe; data expected one cycle later |
| mem_rdata | input | 8 | Memory read byte |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_code | output | 8 | Command byte, valid with `cmd_valid` |

## Verification
A wrong bit counter or decoder state shows up on the same transaction. A write lands at the wrong address or a write strobe is missing. A read returns a byte shifted by one position or one address, and the error appears within the first data byte. An address register that fails to step or to wrap leaves the second byte of a burst at the same location or at the wrong end of the space, and the memory image exposes this once the burst finishes. Errors in command and reserved-prefix decoding appear within a few clocks of chip select rising, as an extra strobe, a missing strobe or a memory strobe that should not be there.

// File: rtl/spi_mmap_pkg.sv
// Shared types for the SPI memory-mapped target.
// Assumes: header byte 0 carries the operation in bits 7:6.
package spi_mmap_pkg;

    typedef enum logic [2:0] {
        ST_HDR0,   // waiting for header byte 0
        ST_HDR1,   // waiting for header byte 1
        ST_HDR2,   // waiting for header byte 2
        ST_DUMMY,  // read: dummy byte in flight
        ST_RD,     // read: data bytes stream out
        ST_WR,     // write: data bytes stream in
        ST_CMDW,   // command: header seen, waiting for release
        ST_SKIP    // ignore rest of frame
    } dec_state_e;

    localparam logic [1:0] OP_READ  = 2'b00;
    localparam logic [1:0] OP_CMD   = 2'b01;
    localparam logic [1:0] OP_WRITE = 2'b10;
    localparam logic [1:0] OP_RSVD  = 2'b11;

endpackage

// File: rtl/spi_mmap_sync.sv
// Multi-bit level synchronizer for asynchronous pins.
// Assumes: each bit is independent; the chain resets to INIT so the
// idle pin levels are seen without spurious edges after reset.
module spi_mmap_sync #(
    parameter int              WIDTH  = 3,
    parameter int              STAGES = 2,
    parameter logic [WIDTH-1:0] INIT  = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] chain [STAGES];

    // Shift pin samples through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= INIT;
        end else begin
            chain[0] <= async_in;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/spi_mmap_shift.sv
// Byte assembler and MISO shifter for SPI mode 0.
// Assumes: sck_rise/sck_fall are single-cycle pulses already gated by
// frame_active; tx_byte is stable by the falling edge that ends a byte.
module spi_mmap_shift (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_active,
    input  logic       sck_rise,
    input  logic       sck_fall,
    input  logic       mosi_s,
    input  logic       rd_stream,
    input  logic [7:0] tx_byte,
    output logic [7:0] rx_byte,
    output logic       byte_done,
    output logic       miso
);

    logic [2:0] bit_cnt;
    logic [6:0] rx_part;
    logic [7:0] tx_sh;

    // Collect MOSI bits on rising edges and flag each completed byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt   <= '0;
            rx_part   <= '0;
            rx_byte   <= '0;
            byte_done <= 1'b0;
        end else begin
            byte_done <= 1'b0;
            if (!frame_active) begin
                bit_cnt <= '0;
                rx_part <= '0;
            end else if (sck_rise) begin
                bit_cnt <= bit_cnt + 3'd1;
                rx_part <= {rx_part[5:0], mosi_s};
                if (bit_cnt == 3'd7) begin
                    rx_byte   <= {rx_part, mosi_s};
                    byte_done <= 1'b1;
                end
            end
        end
    end

    // Load or shift the outgoing byte on falling edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sh <= '0;
        end else if (!frame_active) begin
            tx_sh <= '0;
        end else if (sck_fall) begin
            if (bit_cnt == 3'd0) tx_sh <= rd_stream ? tx_byte : 8'h00;
            else                 tx_sh <= {tx_sh[6:0], 1'b0};
        end
    end

    assign miso = tx_sh[7];

    assert_byte_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |=> !byte_done);

    assert_miso_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_active |=> !miso);

    assert_miso_on_fall_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_active && !sck_fall && $past(frame_active)) |=> $stable(miso));

endmodule

// File: rtl/spi_mmap_decode.sv
// Header decoder, address counter and memory/command port driver.
// Assumes: byte_done pulses are at least five cycles apart; memory
// read data is valid the cycle after mem_re.
module spi_mmap_decode
    import spi_mmap_pkg::*;
#(
    parameter int          ADDR_W   = 22,
    parameter int unsigned ID_ADDR  = 32'h000C_0000,
    parameter logic [7:0]  ID_VALUE = 8'h7C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_active,
    input  logic              frame_end,
    input  logic              byte_done,
    input  logic [7:0]        rx_byte,
    input  logic [7:0]        mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              mem_we,
    output logic              mem_re,
    output logic              rd_stream,
    output logic [7:0]        tx_byte,
    output logic              cmd_valid,
    output logic [7:0]        cmd_code
);

    localparam int HI_W = ADDR_W - 16;
    localparam logic [ADDR_W-1:0] ID_A = ADDR_W'(ID_ADDR);

    dec_state_e        state;
    logic [ADDR_W-1:0] addr;
    logic [7:0]        op_byte;
    logic              tail_zero;
    logic              adv;
    logic              re_d;
    logic              id_d;
    logic              id_hit;
    logic              cmd_ok;

    assign id_hit = (addr == ID_A);
    assign cmd_ok = tail_zero && (state == ST_DUMMY || state == ST_CMDW) &&
                    (op_byte[7:6] == OP_CMD || op_byte == 8'h00);

    // Decode header bytes, drive the memory port and the command strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_HDR0;
            addr      <= '0;
            op_byte   <= '0;
            tail_zero <= 1'b0;
            adv       <= 1'b0;
            mem_we    <= 1'b0;
            mem_re    <= 1'b0;
            mem_wdata <= '0;
            re_d      <= 1'b0;
            id_d      <= 1'b0;
            tx_byte   <= '0;
            cmd_valid <= 1'b0;
            cmd_code  <= '0;
        end else begin
            mem_we    <= 1'b0;
            mem_re    <= 1'b0;
            adv       <= 1'b0;
            cmd_valid <= 1'b0;
            re_d      <= mem_re;
            id_d      <= mem_re && id_hit;
            if (re_d) tx_byte <= id_d ? ID_VALUE : mem_rdata;
            if (adv) addr <= addr + 1'b1;
            if (frame_end && cmd_ok) begin
                cmd_valid <= 1'b1;
                cmd_code  <= op_byte;
            end
            if (!frame_active) begin
                state <= ST_HDR0;
            end else if (byte_done) begin
                case (state)
                    ST_HDR0: begin
                        op_byte   <= rx_byte;
                        addr[ADDR_W-1:16] <= rx_byte[HI_W-1:0];
                        tail_zero <= 1'b1;
                        state     <= ST_HDR1;
                    end
                    ST_HDR1: begin
                        addr[15:8] <= rx_byte;
                        tail_zero  <= (rx_byte == 8'h00);
                        state      <= ST_HDR2;
                    end
                    ST_HDR2: begin
                        addr[7:0] <= rx_byte;
                        tail_zero <= tail_zero && (rx_byte == 8'h00);
                        case (op_byte[7:6])
                            OP_WRITE: state <= ST_WR;
                            OP_READ:  state <= ST_DUMMY;
                            OP_CMD:   state <= ST_CMDW;
                            default:  state <= ST_SKIP;
                        endcase
                    end
                    ST_DUMMY: begin
                        mem_re <= 1'b1;
                        adv    <= 1'b1;
                        state  <= ST_RD;
                    end
                    ST_RD: begin
                        mem_re <= 1'b1;
                        adv    <= 1'b1;
                    end
                    ST_WR: begin
                        mem_we    <= !id_hit;
                        mem_wdata <= rx_byte;
                        adv       <= 1'b1;
                    end
                    ST_CMDW: state <= ST_SKIP;
                    default: ;
                endcase
            end
        end
    end

    assign mem_addr  = addr;
    assign rd_stream = (state == ST_RD);

    assert_we_after_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> ($past(byte_done) && $past(state) == ST_WR));

    assert_we_re_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));

    assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we || mem_re) |=> (addr == $past(addr) + 1'b1));

    assert_id_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr != ID_A));

    assert_cmd_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    assert_cmd_on_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_valid) |-> $past(frame_end));

    assert_rsvd_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SKIP) |-> (!mem_we && !mem_re));

endmodule

// File: rtl/spi_mmap_target.sv
// SPI mode-0 target giving a host byte access to a memory port.
// Assumes: pins are asynchronous to clk; each SCK phase lasts at least
// five clk cycles; memory read data follows mem_re by one cycle.
module spi_mmap_target
    import spi_mmap_pkg::*;
#(
    parameter int          ADDR_W      = 22,
    parameter int          SYNC_STAGES = 2,
    parameter int unsigned ID_ADDR     = 32'h000C_0000,
    parameter logic [7:0]  ID_VALUE    = 8'h7C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sck,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              mem_we,
    output logic              mem_re,
    input  logic [7:0]        mem_rdata,
    output logic              cmd_valid,
    output logic [7:0]        cmd_code
);

    localparam int PIN_W = 3;

    logic [PIN_W-1:0] pins_s;
    logic             sck_q;
    logic             cs_q;
    logic             frame_active;
    logic             frame_end;
    logic             sck_rise;
    logic             sck_fall;
    logic             byte_done;
    logic [7:0]       rx_byte;
    logic [7:0]       tx_byte;
    logic             rd_stream;

    spi_mmap_sync #(
        .WIDTH (PIN_W),
        .STAGES(SYNC_STAGES),
        .INIT  (3'b100)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_in({spi_cs_n, spi_sck, spi_mosi}),
        .sync_out(pins_s)
    );

    // Remember previous synchronized SCK and chip select for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q <= 1'b0;
            cs_q  <= 1'b1;
        end else begin
            sck_q <= pins_s[1];
            cs_q  <= pins_s[2];
        end
    end

    assign frame_active = !pins_s[2];
    assign frame_end    = pins_s[2] && !cs_q;
    assign sck_rise     = frame_active && pins_s[1] && !sck_q;
    assign sck_fall     = frame_active && !pins_s[1] && sck_q;

    spi_mmap_shift u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_active(frame_active),
        .sck_rise    (sck_rise),
        .sck_fall    (sck_fall),
        .mosi_s      (pins_s[0]),
        .rd_stream   (rd_stream),
        .tx_byte     (tx_byte),
        .rx_byte     (rx_byte),
        .byte_done   (byte_done),
        .miso        (spi_miso)
    );

    spi_mmap_decode #(
        .ADDR_W  (ADDR_W),
        .ID_ADDR (ID_ADDR),
        .ID_VALUE(ID_VALUE)
    ) u_decode (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_active(frame_active),
        .frame_end   (frame_end),
        .byte_done   (byte_done),
        .rx_byte     (rx_byte),
        .mem_rdata   (mem_rdata),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .mem_we      (mem_we),
        .mem_re      (mem_re),
        .rd_stream   (rd_stream),
        .tx_byte     (tx_byte),
        .cmd_valid   (cmd_valid),
        .cmd_code    (cmd_code)
    );

    assert_miso_only_stream_R4: assert property (@(posedge clk) disable iff (!rst_n)
        spi_miso |-> rd_stream);

    assert_no_strobe_framed_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we || mem_re) |-> $past(frame_active));

endmodule

// File: tb/spi_mmap_target_bench.sv
module spi_mmap_target_bench;

    localparam int          H       = 6;
    localparam logic [21:0] ID_A    = 22'h0C0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sck = 1'b0;
    logic        cs_n = 1'b1;
    logic        mosi = 1'b0;
    logic        miso;
    logic [21:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_we;
    logic        mem_re;
    logic [7:0]  mem_rdata = 8'h00;
    logic        cmd_valid;
    logic [7:0]  cmd_code;

    always #4 clk = ~clk;

    spi_mmap_target u_spi_mmap_target (
        .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n),
        .spi_mosi(mosi), .spi_miso(miso), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
        .mem_rdata(mem_rdata), .cmd_valid(cmd_valid), .cmd_code(cmd_code)
    );

    logic [7:0] dev_mem [256];
    logic [7:0] exp_mem [256];
    logic [7:0] tx_buf  [16];
    logic [7:0] rx_buf  [16];
    logic [7:0] wr_data [12];
    int n_chk = 0, n_bad = 0;
    int we_cnt = 0, re_cnt = 0, cmd_cnt = 0;
    logic [7:0] last_cmd = 8'h00;
    bit done = 1'b0;

    function automatic logic [7:0] init_val(int i);
        return 8'(i * 13 + 5);
    endfunction

    // Synchronous memory model behind the port.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) dev_mem[i] <= init_val(i);
        end else begin
            if (mem_we) dev_mem[mem_addr[7:0]] <= mem_wdata;
            if (mem_re) mem_rdata <= dev_mem[mem_addr[7:0]];
        end
    end

    // Strobe counters, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_we) we_cnt++;
            if (mem_re) re_cnt++;
            if (cmd_valid) begin cmd_cnt++; last_cmd = cmd_code; end
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp_v);
        n_chk++;
        if (act !== exp_v) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp_v);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    // One chip-select frame: nbytes full bytes plus tail_bits extra bits.
    task automatic spi_frame(int nbytes, int tail_bits);
        cs_n = 1'b0;
        tick(H);
        for (int b = 0; b < nbytes + (tail_bits > 0 ? 1 : 0); b++) begin
            int nb;
            logic [7:0] rv;
            nb = (b < nbytes) ? 8 : tail_bits;
            rv = 8'h00;
            for (int i = 0; i < nb; i++) begin
                mosi = tx_buf[b][7-i];
                tick(H);
                rv[7-i] = miso;
                sck = 1'b1;
                tick(H);
                sck = 1'b0;
            end
            rx_buf[b] = rv;
        end
        tick(H);
        cs_n = 1'b1;
        mosi = 1'b0;
        tick(4 * H);
    endtask

    task automatic set_hdr(logic [1:0] op, logic [21:0] a);
        tx_buf[0] = {op, a[21:16]};
        tx_buf[1] = a[15:8];
        tx_buf[2] = a[7:0];
    endtask

    task automatic wr_burst(logic [21:0] a, int n, int exp_we);
        int we0;
        we0 = we_cnt;
        set_hdr(2'b10, a);
        for (int k = 0; k < n; k++) begin
            logic [21:0] ak;
            ak = a + 22'(k);
            tx_buf[3+k] = wr_data[k];
            if (ak != ID_A) exp_mem[ak[7:0]] = wr_data[k];
        end
        spi_frame(3 + n, 0);
        chk("R2 R3 write strobe count", 32'(we_cnt - we0), 32'(exp_we));
    endtask

    task automatic rd_burst(logic [21:0] a, int n);
        set_hdr(2'b00, a);
        tx_buf[3] = 8'hA5;
        for (int k = 0; k < n; k++) tx_buf[4+k] = 8'h5A;
        spi_frame(4 + n, 0);
        for (int k = 0; k < 4; k++) chk("R4 miso low in header/dummy", 32'(rx_buf[k]), 32'h0);
        for (int k = 0; k < n; k++) begin
            logic [21:0] ak;
            logic [7:0]  ev;
            ak = a + 22'(k);
            ev = (ak == ID_A) ? 8'h7C : exp_mem[ak[7:0]];
            chk("R1 R4 R5 R6 read byte", 32'(rx_buf[4+k]), 32'(ev));
        end
    endtask

    task automatic cmd_frame(logic [7:0] b0, logic [7:0] b1, logic [7:0] b2,
                             int nbytes, int exp_pulses, string tag);
        int c0, w0, r0;
        c0 = cmd_cnt; w0 = we_cnt; r0 = re_cnt;
        tx_buf[0] = b0; tx_buf[1] = b1; tx_buf[2] = b2; tx_buf[3] = 8'h00;
        spi_frame(nbytes, 0);
        chk(tag, 32'(cmd_cnt - c0), 32'(exp_pulses));
        if (exp_pulses > 0) chk("R7 command code", 32'(last_cmd), 32'(b0));
        chk("R7 no memory access on command", 32'((we_cnt - w0) + (re_cnt - r0)), 32'h0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) exp_mem[i] = init_val(i);
        tick(6);
        rst_n = 1'b1;
        tick(2);
        // R10: quiet outputs after reset
        chk("R10 miso after reset", 32'(miso), 32'h0);
        chk("R10 mem_we after reset", 32'(mem_we), 32'h0);
        chk("R10 mem_re after reset", 32'(mem_re), 32'h0);
        chk("R10 cmd_valid after reset", 32'(cmd_valid), 32'h0);

        // Write sweep over start addresses and lengths (R2 R3 R5)
        for (int s = 0; s < 4; s++) begin
            for (int n = 1; n <= 5; n += 2) begin
                logic [21:0] a;
                a = {6'(s), 16'h0} | 22'(s * 48 + n * 8);
                for (int k = 0; k < n; k++) wr_data[k] = 8'(s * 71 + n * 29 + k * 37 + 1);
                wr_burst(a, n, n);
            end
        end

        // Read sweep (R1 R4 R5)
        for (int s = 0; s < 4; s++) begin
            for (int n = 1; n <= 5; n += 2) begin
                rd_burst({6'(s), 16'h0} | 22'(s * 48 + 8), n);
            end
        end

        // Little-endian word (R5)
        wr_data[0] = 8'h0D; wr_data[1] = 8'hF0; wr_data[2] = 8'hAD; wr_data[3] = 8'h8B;
        wr_burst(22'h002080, 4, 4);
        rd_burst(22'h002080, 4);
        chk("R5 little-endian word", {rx_buf[7], rx_buf[6], rx_buf[5], rx_buf[4]}, 32'h8BADF00D);

        // Address wrap (R5)
        wr_data[0] = 8'h11; wr_data[1] = 8'h22; wr_data[2] = 8'h33;
        wr_burst(22'h3FFFFE, 3, 3);
        rd_burst(22'h3FFFFE, 3);

        // Identification byte (R6)
        rd_burst(ID_A - 22'd1, 3);
        wr_data[0] = 8'h99;
        wr_burst(ID_A, 1, 0);
        wr_data[0] = 8'h44; wr_data[1] = 8'h55; wr_data[2] = 8'h66;
        wr_burst(ID_A - 22'd1, 3, 2);
        rd_burst(ID_A - 22'd1, 3);

        // Host commands (R7)
        cmd_frame(8'h68, 8'h00, 8'h00, 3, 1, "R7 core reset strobe");
        cmd_frame(8'h00, 8'h00, 8'h00, 3, 1, "R7 wake strobe");
        cmd_frame(8'h4C, 8'h00, 8'h00, 3, 1, "R7 prefix 01 strobe");
        cmd_frame(8'h68, 8'h01, 8'h00, 3, 0, "R7 nonzero tail no strobe");
        cmd_frame(8'h68, 8'h00, 8'h00, 4, 0, "R7 long frame no strobe");
        cmd_frame(8'h05, 8'h00, 8'h00, 3, 0, "R7 aborted read no strobe");

        // Reserved prefix (R8)
        begin
            int c0, w0, r0;
            c0 = cmd_cnt; w0 = we_cnt; r0 = re_cnt;
            tx_buf[0] = 8'hC1; tx_buf[1] = 8'h00; tx_buf[2] = 8'h10;
            for (int k = 3; k < 8; k++) tx_buf[k] = 8'hFF;
            spi_frame(8, 0);
            chk("R8 reserved no write", 32'(we_cnt - w0), 32'h0);
            chk("R8 reserved no read", 32'(re_cnt - r0), 32'h0);
            chk("R8 reserved no strobe", 32'(cmd_cnt - c0), 32'h0);
            for (int k = 0; k < 8; k++) chk("R8 reserved miso low", 32'(rx_buf[k]), 32'h0);
        end

        // Abort mid-byte (R9)
        begin
            int w0, c0;
            w0 = we_cnt;
            set_hdr(2'b10, 22'h000340);
            tx_buf[3] = 8'hE7; tx_buf[4] = 8'h99;
            exp_mem[8'h40] = 8'hE7;
            spi_frame(4, 5);
            chk("R9 partial byte not written", 32'(we_cnt - w0), 32'h1);
            rd_burst(22'h000340, 2);
            c0 = cmd_cnt;
            tx_buf[0] = 8'h80; tx_buf[1] = 8'hFF;
            spi_frame(1, 3);
            tx_buf[0] = 8'h68; tx_buf[1] = 8'h00; tx_buf[2] = 8'h00;
            spi_frame(3, 0);
            chk("R9 fresh header after abort", 32'(cmd_cnt - c0), 32'h1);
        end

        // Final memory image (R3 R5 R6)
        begin
            int mism;
            mism = 0;
            for (int i = 0; i < 256; i++) if (dev_mem[i] !== exp_mem[i]) mism++;
            chk("R3 R5 memory image", 32'(mism), 32'h0);
        end

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog R10 actual=running expected=finished");
            summary();
            $finish;
        end
    end

endmodule